// File: doc/BRIEF.md
# DDR3 Command Decoder and Bank State Tracker

This block sits on the device side of a DDR3-style command bus. On every rising clock it samples chip select, the row strobe, the column strobe, write enable, clock enable, the bank lines and the address lines. From these it works out which command was issued. It also reads the address bits whose meaning depends on the command. Bit 10 selects auto-precharge on a read or write, and selects all banks on a precharge. Bit 12 selects a chopped burst on a read or write.

The block keeps an open or idle flag for each bank and updates these flags as rows are activated and closed. It also tracks the power state. When clock enable is taken low, the block enters precharge power-down if every bank is idle and active power-down if any row is open. A refresh issued with clock enable low and all banks idle enters self-refresh. The self-refresh exit is reported as soon as clock enable rises, without waiting for a clock edge.

Every accepted command appears one clock later as a one-hot strobe, together with its address, its bank and its flags. A read or write to a bank with no open row is not forwarded. Instead it sets a sticky error flag.

Top module: `ddrc_tracker`

## Requirements
- R1: While `cs_n` is high at a rising edge, no command is accepted. `cmd_oh` is all zero on the next cycle and no bank flag changes.
- R2: The command code is {`ras_n`,`cas_n`,`we_n`}, and a forwarded command sets bit `cmd_oh[code]` one cycle later. The codes are 0 mode-register-set, 1 refresh, 2 precharge, 3 activate, 4 write, 5 read, 6 ZQ calibration and 7 no-operation. At most one bit of `cmd_oh` is set.
- R3: An activate opens the bank named by `ba`. It outputs the full address as the row on `cmd_addr` and the bank on `cmd_bank`.
- R4: A read or write to an open bank outputs the column on `cmd_addr`, with bits 10 and 12 forced to zero. `auto_pre` equals address bit 10. When bit 10 is high, the bank is closed in the same cycle.
- R5: On a read or write, `burst_chop` is the inverse of address bit 12 (1 = chopped burst). On every other command it is 0.
- R6: A precharge with address bit 10 low closes only bank `ba`. With bit 10 high it closes every bank, and it raises `pre_all`.
- R7: A mode-register-set outputs the address as the opcode on `cmd_addr` and `ba` as the register select on `cmd_bank`. It leaves every bank flag unchanged.
- R8: When `cke` is low at an edge in the normal state (`pwr_state` 0), the block enters state 1 (precharge power-down) if all banks are idle, or state 2 (active power-down) otherwise. While powered down, commands are ignored. `cke` high at an edge returns the block to state 0.
- R9: A refresh code with `cs_n` low, sampled with `cke` low while all banks are idle, enters state 3 (self-refresh). While in self-refresh, `pwr_state` shows 0 as soon as `cke` is high, with no clock edge needed.
- R10: A read or write to an idle bank is not forwarded: `cmd_oh` stays zero. It sets `proto_err`, which stays high until reset.
- R11: `rst_n` low asynchronously clears all outputs, all bank flags, the power state and `proto_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 3 | Bank address / mode-register select |
| addr | input | 16 | Address / opcode bus |
| cmd_oh | output | 8 | One-hot forwarded command, indexed by code |
| cmd_addr | output | 16 | Row, column or opcode of the forwarded command |
| cmd_bank | output | 3 | Bank or register select of the forwarded command |
| auto_pre | output | 1 | Auto-precharge requested by a read or write |
| burst_chop | output | 1 | Chopped burst requested by a read or write |
| pre_all | output | 1 | Precharge applied to all banks |
| bank_open | output | 8 | Per-bank open-row flags |
| pwr_state | output | 2 | 0 normal, 1 precharge power-down, 2 active power-down, 3 self-refresh |
| proto_err | output | 1 | Sticky flag for a read or write to an idle bank |

## Verification
The directed sequence first walks each command code through the decoder. It covers both values of bit 10 on reads, writes and precharges, and both values of bit 12, so that the two meanings of each dual-purpose bit are told apart. Clock enable is then dropped with all banks idle, with a row open, and together with a refresh code. This separates the three low-power entries, and a mid-cycle rise of clock enable shows the self-refresh exit before any clock edge. A long stretch of random commands and deselects, with clock enable occasionally low, then exercises accesses to closed banks and the sticky error against the bench's own model. A mid-run reset confirms that everything clears.

// File: rtl/ddrc_pkg.sv
package ddrc_pkg;

    // command code = {ras_n, cas_n, we_n} while cs_n is low
    localparam logic [2:0] CODE_MRS = 3'd0;
    localparam logic [2:0] CODE_REF = 3'd1;
    localparam logic [2:0] CODE_PRE = 3'd2;
    localparam logic [2:0] CODE_ACT = 3'd3;
    localparam logic [2:0] CODE_WR  = 3'd4;
    localparam logic [2:0] CODE_RD  = 3'd5;
    localparam logic [2:0] CODE_ZQC = 3'd6;
    localparam logic [2:0] CODE_NOP = 3'd7;
    localparam int         CODE_N   = 8;

    typedef enum logic [1:0] {
        PWR_RUN  = 2'd0,
        PWR_PPD  = 2'd1,
        PWR_APD  = 2'd2,
        PWR_SREF = 2'd3
    } pwr_e;

endpackage

// File: rtl/ddrc_decode.sv
module ddrc_decode
    import ddrc_pkg::*;
(
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    output logic [2:0]        code,
    output logic [CODE_N-1:0] code_oh
);
    assign code = {ras_n, cas_n, we_n};

    for (genvar i = 0; i < CODE_N; i++) begin : g_oh
        assign code_oh[i] = (code == 3'(i));
    end
endmodule

// File: rtl/ddrc_bank_tbl.sv
module ddrc_bank_tbl #(
    parameter int BA_W  = 3,
    parameter int NBANK = 1 << BA_W
) (
    input  logic [NBANK-1:0] open_q,
    input  logic [BA_W-1:0]  ba,
    input  logic             set_one,
    input  logic             clr_one,
    input  logic             clr_all,
    output logic [NBANK-1:0] open_d,
    output logic             all_idle,
    output logic             sel_open
);
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic hit;
        assign hit = (ba == BA_W'(b));
        always_comb begin
            open_d[b] = open_q[b];
            if (clr_all || (clr_one && hit)) open_d[b] = 1'b0;
            else if (set_one && hit)         open_d[b] = 1'b1;
        end
    end

    assign all_idle = ~|open_q;
    assign sel_open = open_q[ba];
endmodule

// File: rtl/ddrc_pwr.sv
module ddrc_pwr
    import ddrc_pkg::*;
(
    input  pwr_e pwr_q,
    input  logic cke,
    input  logic all_idle,
    input  logic sref_req,
    output pwr_e pwr_d,
    output pwr_e pwr_vis,
    output logic run
);
    always_comb begin
        pwr_d = pwr_q;
        unique case (pwr_q)
            PWR_RUN: begin
                if (!cke) begin
                    if (!all_idle)     pwr_d = PWR_APD;
                    else if (sref_req) pwr_d = PWR_SREF;
                    else               pwr_d = PWR_PPD;
                end
            end
            default: if (cke) pwr_d = PWR_RUN;
        endcase
    end

    // self-refresh exit is reported combinationally on the clock-enable rise
    assign pwr_vis = (pwr_q == PWR_SREF && cke) ? PWR_RUN : pwr_q;
    assign run     = (pwr_q == PWR_RUN) && cke;
endmodule

// File: rtl/ddrc_tracker.sv
module ddrc_tracker
    import ddrc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BA_W   = 3,
    parameter int AP_BIT = 10,
    parameter int BC_BIT = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cke,
    input  logic                    cs_n,
    input  logic                    ras_n,
    input  logic                    cas_n,
    input  logic                    we_n,
    input  logic [BA_W-1:0]         ba,
    input  logic [ADDR_W-1:0]       addr,
    output logic [CODE_N-1:0]       cmd_oh,
    output logic [ADDR_W-1:0]       cmd_addr,
    output logic [BA_W-1:0]         cmd_bank,
    output logic                    auto_pre,
    output logic                    burst_chop,
    output logic                    pre_all,
    output logic [(1<<BA_W)-1:0]    bank_open,
    output logic [1:0]              pwr_state,
    output logic                    proto_err
);
    localparam int NBANK = 1 << BA_W;
    localparam logic [ADDR_W-1:0] COL_MASK =
        ~((ADDR_W'(1) << AP_BIT) | (ADDR_W'(1) << BC_BIT));

    typedef struct packed {
        logic [CODE_N-1:0] oh;
        logic [ADDR_W-1:0] addr;
        logic [BA_W-1:0]   bank;
        logic              ap;
        logic              bc;
        logic              all;
        logic [NBANK-1:0]  open;
        pwr_e              pwr;
        logic              err;
    } state_t;

    state_t st_d, st_q;

    logic [2:0]        code;
    logic [CODE_N-1:0] code_oh;
    logic [NBANK-1:0]  open_nx;
    logic              all_idle, sel_open, run;
    logic              accept, is_rw, bad, fwd;
    logic              set_one, clr_one, clr_all;
    pwr_e              pwr_nx, pwr_vis;

    ddrc_decode u_dec (
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .code    (code),
        .code_oh (code_oh)
    );

    ddrc_bank_tbl #(.BA_W(BA_W), .NBANK(NBANK)) u_banks (
        .open_q   (st_q.open),
        .ba       (ba),
        .set_one  (set_one),
        .clr_one  (clr_one),
        .clr_all  (clr_all),
        .open_d   (open_nx),
        .all_idle (all_idle),
        .sel_open (sel_open)
    );

    ddrc_pwr u_pwr (
        .pwr_q    (st_q.pwr),
        .cke      (cke),
        .all_idle (all_idle),
        .sref_req (!cs_n && code == CODE_REF),
        .pwr_d    (pwr_nx),
        .pwr_vis  (pwr_vis),
        .run      (run)
    );

    always_comb begin
        accept  = run && !cs_n;
        is_rw   = accept && (code == CODE_RD || code == CODE_WR);
        bad     = is_rw && !sel_open;
        fwd     = accept && !bad;
        set_one = fwd && code == CODE_ACT;
        clr_one = fwd && ((code == CODE_PRE && !addr[AP_BIT]) ||
                          (is_rw && addr[AP_BIT]));
        clr_all = fwd && code == CODE_PRE && addr[AP_BIT];

        st_d      = st_q;
        st_d.oh   = fwd ? code_oh : '0;
        st_d.addr = '0;
        st_d.bank = '0;
        st_d.ap   = 1'b0;
        st_d.bc   = 1'b0;
        st_d.all  = clr_all;
        st_d.open = open_nx;
        st_d.pwr  = pwr_nx;
        st_d.err  = st_q.err | bad;

        if (fwd) begin
            unique case (code)
                CODE_ACT, CODE_MRS: begin
                    st_d.addr = addr;
                    st_d.bank = ba;
                end
                CODE_RD, CODE_WR: begin
                    st_d.addr = addr & COL_MASK;
                    st_d.bank = ba;
                    st_d.ap   = addr[AP_BIT];
                    st_d.bc   = !addr[BC_BIT];
                end
                CODE_PRE: st_d.bank = ba;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.pwr  <= PWR_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_oh     = st_q.oh;
    assign cmd_addr   = st_q.addr;
    assign cmd_bank   = st_q.bank;
    assign auto_pre   = st_q.ap;
    assign burst_chop = st_q.bc;
    assign pre_all    = st_q.all;
    assign bank_open  = st_q.open;
    assign pwr_state  = pwr_vis;
    assign proto_err  = st_q.err;
endmodule

// File: rtl/ddrc_tracker_chk.sv
module ddrc_tracker_chk #(
    parameter int BA_W = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cke,
    input logic                 cs_n,
    input logic [7:0]           cmd_oh,
    input logic [BA_W-1:0]      cmd_bank,
    input logic                 auto_pre,
    input logic                 burst_chop,
    input logic                 pre_all,
    input logic [(1<<BA_W)-1:0] bank_open,
    input logic [1:0]           pwr_state,
    input logic                 proto_err
);
    AST_DESELECT_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (cmd_oh == '0)); // R1

    AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_oh)); // R2

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oh[3] |-> bank_open[cmd_bank]); // R3

    AST_AP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_oh[4] || cmd_oh[5]) && auto_pre) |-> !bank_open[cmd_bank]); // R4

    AST_RW_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_oh[4] || cmd_oh[5]) && !auto_pre) |-> bank_open[cmd_bank]); // R4

    AST_CHOP_RW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        burst_chop |-> (cmd_oh[4] || cmd_oh[5])); // R5

    AST_PREALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        pre_all |-> (cmd_oh[2] && bank_open == '0)); // R6

    AST_PD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd1 || pwr_state == 2'd2) |-> (cmd_oh == '0)); // R8

    AST_PPD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd1) |-> (bank_open == '0)); // R8

    AST_SREF_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd3) |-> !cke); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err); // R10
endmodule

bind ddrc_tracker ddrc_tracker_chk #(.BA_W(BA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .cs_n       (cs_n),
    .cmd_oh     (cmd_oh),
    .cmd_bank   (cmd_bank),
    .auto_pre   (auto_pre),
    .burst_chop (burst_chop),
    .pre_all    (pre_all),
    .bank_open  (bank_open),
    .pwr_state  (pwr_state),
    .proto_err  (proto_err)
);

// File: tb/tb_ddrc_tracker.sv
module tb_ddrc_tracker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1;
    logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [2:0]  ba = '0;
    logic [15:0] addr = '0;

    logic [7:0]  cmd_oh;
    logic [15:0] cmd_addr;
    logic [2:0]  cmd_bank;
    logic        auto_pre, burst_chop, pre_all, proto_err;
    logic [7:0]  bank_open;
    logic [1:0]  pwr_state;

    int checks = 0;
    int errors = 0;
    string cur_req = "R11";

    ddrc_tracker dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .cmd_oh(cmd_oh), .cmd_addr(cmd_addr), .cmd_bank(cmd_bank),
        .auto_pre(auto_pre), .burst_chop(burst_chop), .pre_all(pre_all),
        .bank_open(bank_open), .pwr_state(pwr_state), .proto_err(proto_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    int          m_st;
    bit          m_open [8];
    bit          m_err;
    logic [7:0]  m_oh;
    logic [15:0] m_addr;
    logic [2:0]  m_bank;
    bit          m_ap, m_bc, m_all;

    function automatic bit any_open();
        foreach (m_open[i]) if (m_open[i]) return 1'b1;
        return 1'b0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_err = 0; m_oh = 0; m_addr = 0; m_bank = 0;
            m_ap = 0; m_bc = 0; m_all = 0;
            foreach (m_open[i]) m_open[i] = 0;
        end else begin
            int code;
            code = {ras_n, cas_n, we_n};
            m_oh = 0; m_addr = 0; m_bank = 0; m_ap = 0; m_bc = 0; m_all = 0;
            if (m_st != 0) begin
                if (cke) m_st = 0;
            end else if (!cke) begin
                if (any_open())                 m_st = 2;
                else if (!cs_n && code == 1)    m_st = 3;
                else                            m_st = 1;
            end else if (!cs_n) begin
                if ((code == 4 || code == 5) && !m_open[ba]) begin
                    m_err = 1;
                end else begin
                    m_oh[code] = 1'b1;
                    if (code == 0) begin
                        m_addr = addr; m_bank = ba;
                    end else if (code == 2) begin
                        m_bank = ba;
                        if (addr[10]) begin
                            m_all = 1;
                            foreach (m_open[i]) m_open[i] = 0;
                        end else m_open[ba] = 0;
                    end else if (code == 3) begin
                        m_addr = addr; m_bank = ba; m_open[ba] = 1;
                    end else if (code == 4 || code == 5) begin
                        m_addr = addr; m_addr[10] = 0; m_addr[12] = 0;
                        m_bank = ba; m_ap = addr[10]; m_bc = !addr[12];
                        if (addr[10]) m_open[ba] = 0;
                    end
                end
            end
        end
    end

    task automatic chk(input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [7:0] eo;
        int evis;
        foreach (m_open[i]) eo[i] = m_open[i];
        evis = (m_st == 3 && cke) ? 0 : m_st;
        chk("cmd_oh", cmd_oh, m_oh);
        chk("cmd_addr", cmd_addr, m_addr);
        chk("cmd_bank", cmd_bank, m_bank);
        chk("auto_pre", auto_pre, m_ap);
        chk("burst_chop", burst_chop, m_bc);
        chk("pre_all", pre_all, m_all);
        chk("bank_open", bank_open, eo);
        chk("pwr_state", pwr_state, evis);
        chk("proto_err", proto_err, m_err);
    endtask

    task automatic step(input bit k, input bit cs, input int code,
                        input int b, input int a);
        cke = k; cs_n = cs;
        {ras_n, cas_n, we_n} = 3'(code);
        ba = 3'(b); addr = 16'(a);
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        compare_all();
        rst_n = 1'b1;
        step(1, 0, 7, 0, 0);                 // NOP
        cur_req = "R1";
        step(1, 1, 3, 2, 16'h1234);          // deselected activate
        chk("R1 bank2 still idle", bank_open[2], 0);
        cur_req = "R3";
        step(1, 0, 3, 2, 16'h1234);
        chk("R3 row on cmd_addr", cmd_addr, 16'h1234);
        cur_req = "R5";
        step(1, 0, 5, 2, 16'h1400);          // read, a12=1, a10=1? no: a10 bit
        cur_req = "R4";
        step(1, 0, 3, 2, 16'h0042);
        step(1, 0, 5, 2, 16'h1045);          // read full burst, no AP
        chk("R5 full burst", burst_chop, 0);
        step(1, 0, 4, 2, 16'h0433);          // write chopped, auto-precharge
        chk("R4 column masked", cmd_addr, 16'h0033);
        chk("R4 bank closed", bank_open[2], 0);
        cur_req = "R10";
        step(1, 0, 5, 2, 16'h0001);
        chk("R10 not forwarded", cmd_oh, 0);
        chk("R10 error set", proto_err, 1);
        cur_req = "R6";
        step(1, 0, 3, 1, 16'h0100);
        step(1, 0, 3, 5, 16'h0500);
        step(1, 0, 2, 1, 16'h0000);          // single precharge
        chk("R6 only bank1 closed", bank_open, 8'h20);
        step(1, 0, 3, 6, 16'h0600);
        step(1, 0, 2, 0, 16'h0400);          // precharge all
        chk("R6 all idle", bank_open, 8'h00);
        cur_req = "R7";
        step(1, 0, 0, 2, 16'h0A5A);
        chk("R7 opcode", cmd_addr, 16'h0A5A);
        cur_req = "R2";
        step(1, 0, 6, 0, 16'h0400);
        chk("R2 ZQ bit", cmd_oh, 8'h40);
        step(1, 0, 1, 0, 0);
        chk("R2 refresh bit", cmd_oh, 8'h02);
        cur_req = "R8";
        step(0, 1, 7, 0, 0);
        chk("R8 precharge power-down", pwr_state, 1);
        step(0, 0, 3, 4, 16'h0044);
        step(1, 0, 3, 4, 16'h0044);          // exit edge, command ignored
        chk("R8 exit to normal", pwr_state, 0);
        chk("R8 bank4 idle", bank_open[4], 0);
        step(1, 0, 3, 3, 16'h0033);
        step(0, 1, 7, 0, 0);
        chk("R8 active power-down", pwr_state, 2);
        step(1, 1, 7, 0, 0);
        step(1, 0, 2, 0, 16'h0400);
        cur_req = "R9";
        step(0, 0, 1, 0, 0);
        chk("R9 self-refresh", pwr_state, 3);
        step(0, 0, 3, 1, 0);
        #1 cke = 1'b1;
        #1 chk("R9 async exit", pwr_state, 0);
        @(posedge clk); @(negedge clk);
        compare_all();
        cur_req = "R2";
        for (int n = 0; n < 2000; n++) begin
            int r;
            r = $urandom_range(0, 99);
            step(r > 4, r > 85, $urandom_range(0, 7), $urandom_range(0, 7),
                 $urandom_range(0, 16'hFFFF));
        end
        cur_req = "R11";
        #2 rst_n = 1'b0;
        #1 compare_all();
        chk("R11 error cleared", proto_err, 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1, 0, 7, 0, 0);
        finish_run();
    end
endmodule